// File: doc/BRIEF.md
# Period-Qualified Clock Gate

This block passes or blocks a slow input clock one whole period at a time. A period runs from one rising edge of the input clock to the next. While a period is in progress, the block records whether the enable was ever seen high and whether it was ever seen low. That record decides whether the gate is open or closed for the period that follows.

If the enable was high for the whole period, the next period is passed through. If it was low for the whole period, the output is held high for the next period. If it was seen at both levels, the gate status flips.

A faster free-running system clock oversamples both the input clock and the enable. Each goes through its own two-flop synchroniser, and input clock edges are found in that domain. The output is the registered, synchronised input clock when the gate is open, and a constant 1 when it is closed. It therefore lags the input clock by a fixed number of system-clock cycles.

Top module: `period_clock_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `clk_out` is 1 and the gate is closed, whatever `clk_in` does.
- R2: When `gate_en` was 1 on every sampled cycle of an input period, `clk_out` follows `clk_in` during the next period, delayed by SYNC_STAGES+1 system-clock cycles (3 by default).
- R3: When `gate_en` was 0 on every sampled cycle of an input period, `clk_out` stays at 1 throughout the next period.
- R4: When `gate_en` was sampled at both 1 and 0 within a period, the gate status for the next period is the inverse of the current one.
- R5: The first period after reset only gathers enable history: its status is closed, whatever the enable does before or during it.
- R6: The gate status changes only on the system-clock edge that follows a detected rising edge of the synchronised input clock, and `clk_out` is 1 in the cycle when it changes, so no shortened pulse appears.
- R7: A single system-clock cycle of enable at the opposite level is enough to make a period count as mixed for R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | Free-running oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_in | input | 1 | Slow clock to be gated, asynchronous to `sys_clk` |
| gate_en | input | 1 | Enable, judged over each whole input period |
| clk_out | output | 1 | Gated clock; idles at 1 |

## Verification
The bench uses the default SYNC_STAGES of 2, so the output latency is three system-clock cycles. It drives an input period of eight system-clock cycles, four high and four low, which places the first low output sample and the gate update well inside one period where both can be checked exactly. With this spacing, one-cycle enable pulses, every kind of transition between open, closed and toggled periods, and a reset in the middle of an open period can all be checked at fixed cycle offsets.

// File: rtl/period_clock_gate.sv
module period_clock_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic clk_in,
  input  logic gate_en,
  output logic clk_out
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clk_pipe, en_pipe;
  logic clk_s, en_s, clk_d, rise;
  logic armed, seen_hi, seen_lo, gate_on, gate_nxt, out_q;

  assign clk_s = clk_pipe[TOP];
  assign en_s  = en_pipe[TOP];
  assign rise  = clk_s & ~clk_d;
  assign clk_out = out_q;

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      clk_pipe <= '0;
      en_pipe  <= '0;
      clk_d    <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[TOP-1:0], clk_in};
      en_pipe  <= {en_pipe[TOP-1:0], gate_en};
      clk_d    <= clk_s;
    end

  always_comb
    case ({seen_hi, seen_lo})
      2'b11:   gate_nxt = ~gate_on;
      2'b10:   gate_nxt = 1'b1;
      2'b01:   gate_nxt = 1'b0;
      default: gate_nxt = gate_on;
    endcase

  always_ff @(posedge sys_clk or negedge rst_n)
    if (!rst_n) begin
      armed   <= 1'b0;
      seen_hi <= 1'b0;
      seen_lo <= 1'b0;
      gate_on <= 1'b0;
      out_q   <= 1'b1;
    end else begin
      if (rise) begin
        armed   <= 1'b1;
        seen_hi <= en_s;
        seen_lo <= ~en_s;
        if (armed) gate_on <= gate_nxt;
      end else begin
        seen_hi <= seen_hi | en_s;
        seen_lo <= seen_lo | ~en_s;
      end
      out_q <= gate_on ? clk_s : 1'b1;
    end
endmodule

// File: rtl/period_clock_gate_chk.sv
module period_clock_gate_chk (
  input logic sys_clk,
  input logic rst_n,
  input logic clk_s,
  input logic clk_d,
  input logic armed,
  input logic gate_on,
  input logic clk_out
);
  p_reset_high_r1: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !armed |=> clk_out);
  p_on_follow_r2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    gate_on |=> (clk_out == $past(clk_s)));
  p_off_high_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !gate_on |=> clk_out);
  p_first_closed_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !armed |-> !gate_on);
  p_change_at_edge_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (gate_on != $past(gate_on)) |-> ($past(clk_s) && !$past(clk_d)));
  p_no_runt_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (gate_on != $past(gate_on)) |-> clk_out);
endmodule

bind period_clock_gate period_clock_gate_chk u_chk (
  .sys_clk(sys_clk), .rst_n(rst_n), .clk_s(clk_s), .clk_d(clk_d),
  .armed(armed), .gate_on(gate_on), .clk_out(clk_out)
);

// File: tb/sim_period_clock_gate.sv
`timescale 1ns/1ps
module sim_period_clock_gate;
  logic sys_clk = 1'b0, rst_n = 1'b0, clk_in = 1'b0, gate_en = 1'b0, clk_out;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 sys_clk = ~sys_clk;

  period_clock_gate u0 (.sys_clk(sys_clk), .rst_n(rst_n), .clk_in(clk_in),
                        .gate_en(gate_en), .clk_out(clk_out));

  // modes: 0 low all period, 1 high all period, 2 high then low, 3 low with one-cycle high
  localparam int N = 15;
  localparam logic [2:0] VEC [N] = '{
    {2'd1,1'b0}, {2'd1,1'b1}, {2'd0,1'b1}, {2'd2,1'b0}, {2'd2,1'b1},
    {2'd0,1'b0}, {2'd2,1'b0}, {2'd1,1'b1}, {2'd1,1'b1}, {2'd2,1'b1},
    {2'd0,1'b0}, {2'd3,1'b0}, {2'd1,1'b1}, {2'd2,1'b1}, {2'd0,1'b0}};

  task automatic check(input logic act, input logic exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: clk_out=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic period(input logic [1:0] mode, input logic exp_on, input string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge sys_clk);
      if (i == 3) check(clk_out, 1'b1, {tag, " R6 high phase"});
      if (i == 6) check(clk_out, 1'b1, {tag, " R2 last high"});
      if (i == 7) check(clk_out, exp_on ? 1'b0 : 1'b1, {tag, exp_on ? " R2 follow" : " R3 idle high"});
      clk_in = (i < 4);
      case (mode)
        2'd0: gate_en = 1'b0;
        2'd1: gate_en = 1'b1;
        2'd2: gate_en = (i < 4);
        default: gate_en = (i == 5);
      endcase
    end
  endtask

  initial begin
    repeat (40000) @(posedge sys_clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge sys_clk);
    check(clk_out, 1'b1, "R1 in reset");
    clk_in = 1'b1; gate_en = 1'b1;
    repeat (3) @(negedge sys_clk);
    check(clk_out, 1'b1, "R1 clk toggling in reset");
    clk_in = 1'b0; gate_en = 1'b0;
    @(negedge sys_clk);
    rst_n = 1'b1;
    for (int v = 0; v < N; v++)
      period(VEC[v][2:1], VEC[v][0], $sformatf("vec%0d R4/R7", v));
    period(2'd1, 1'b0, "pre-reset");
    period(2'd1, 1'b1, "open before reset");
    @(negedge sys_clk);
    rst_n = 1'b0; clk_in = 1'b0;
    @(negedge sys_clk);
    check(clk_out, 1'b1, "R1 reset while open");
    @(negedge sys_clk);
    rst_n = 1'b1;
    period(2'd1, 1'b0, "R5 first period");
    period(2'd3, 1'b1, "R5 second period");
    period(2'd1, 1'b0, "R7 pulse toggles");
    period(2'd1, 1'b1, "R2 back open");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule